// File: doc/BRIEF.md
# Two-Tone / Four-Phase Digital Synthesis Modulator

This block is a numerically controlled oscillator built for frequency-shift and phase-shift keying. A 32-bit phase accumulator advances each clock by one of two stored tuning words. A one-bit frequency-select pin picks the tuning word, so a serial data stream on that pin switches the carrier between a mark tone and a space tone. A two-bit phase-select pin picks one of four stored 12-bit phase offsets. That offset is added to the top 12 bits of the accumulator, and the sum addresses a sine lookup. The lookup returns a 10-bit offset-binary sample, with 512 standing for zero.

A host loads the six words through a plain synchronous write port: a strobe, a 3-bit address and a 32-bit data bus. It may write on every clock. Everything runs through a fixed six-stage pipeline. A register write and a select-pin change both take effect at the output exactly six clocks after the edge that samples them, so modulation timing is fully predictable.

The pipeline has no control states. The select capture, word fetch, accumulate, index, lookup and two output stages run every clock, and synchronous reset is the only transition.

Top module: `dds_modulator`

## Requirements
- R1: A synchronous reset clears the accumulator, all six words and every pipeline stage. `sample` reads 512 after each clock edge at which `rst` is high, and stays at 512 until nonzero words are loaded.
- R2: The accumulator adds the selected tuning word once per clock, modulo 2^32. It wraps silently on overflow, and it holds its value when the selected word is zero.
- R3: When `tone_sel` is 0, the tuning word at address 0 drives the accumulator. When `tone_sel` is 1, the word at address 1 drives it.
- R4: `shift_sel` = k (0..3) selects the phase word at address 2+k. That 12-bit word is added modulo 4096 to accumulator bits [31:20] to form the lookup index.
- R5: For lookup index i (0..4095), the sample equals 512 + round(511·sin(2πi/4096)), with halves rounded away from zero. The result is always between 1 and 1023.
- R6: Take a write, or a select-pin value, sampled at clock edge t. It first affects `sample` after edge t+6 and leaves the sample after edge t+5 untouched. For a tuning word, the accumulator value reached at edge t+2 is the first to include it.
- R7: Address decode works as follows. Addresses 0 and 1 load the full 32-bit `wr_data` as a tuning word. Addresses 2 to 5 load only `wr_data[11:0]` as a phase word. Writes to addresses 6 and 7 change no word.
- R8: The write port accepts a new write on every clock. Each write in a back-to-back run lands in its register, and the register holds that value until it is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 3 | Word address: 0-1 tuning words, 2-5 phase words |
| wr_data | input | 32 | Write data |
| tone_sel | input | 1 | Chooses which tuning word drives the accumulator |
| shift_sel | input | 2 | Chooses which phase word is added |
| sample | output | 10 | Offset-binary sine sample |

## Verification
A tuning word of 2^20 with zero phase steps the lookup through all 4096 indices in order. This separates a correct table from errors in quadrant folding, mirroring or rounding. Tuning words near 2^32 exercise accumulator wrap. A pseudo-random tone pattern, and a phase pattern cycling through all four offsets, tell apart correct selection from swapped or stuck selects. Single-step tests with a frozen accumulator pin down the six-clock latency of writes and selects separately. Runs of junk writes to addresses 6 and 7, phase data with upper bits set, and one write per clock tell correct decode from aliasing or dropped writes.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int FTW_W    = 32;
    localparam int PH_W     = 12;
    localparam int OUT_W    = 10;
    localparam int ADDR_W   = 3;
    localparam int N_FREQ   = 2;
    localparam int N_PHASE  = 4;
    localparam int PH_BASE  = N_FREQ;
    localparam int PIPE_LAT = 6;

    localparam int FSEL_W   = $clog2(N_FREQ);
    localparam int PSEL_W   = $clog2(N_PHASE);
    localparam int AMP_W    = OUT_W - 1;
    localparam int QTR_W    = PH_W - 2;
    localparam int QTR_N    = 1 << QTR_W;
    localparam int MID      = 1 << (OUT_W - 1);
    localparam int AMP_MAX  = MID - 1;
    localparam int OUT_DLY  = PIPE_LAT - 4;

    typedef logic [FTW_W-1:0] ftw_t;
    typedef logic [PH_W-1:0]  phase_t;
    typedef logic [OUT_W-1:0] sample_t;

    // Amplitude of the first quarter wave at step q (0..QTR_N), rounded.
    function automatic int quarter_amp(int q);
        real ang;
        real v;
        ang = 2.0 * 3.14159265358979323846 * real'(q) / real'(4 * QTR_N);
        v   = real'(AMP_MAX) * $sin(ang);
        return $rtoi(v + 0.5);
    endfunction
endpackage

// File: rtl/dds_regbank.sv
module dds_regbank
    import dds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  ftw_t              wr_data,
    input  logic [FSEL_W-1:0] fsel,
    input  logic [PSEL_W-1:0] psel,
    output ftw_t              inc_o,
    output phase_t            pofs_o
);
    logic [N_FREQ-1:0][FTW_W-1:0] freq_vec;
    logic [N_PHASE-1:0][PH_W-1:0] phase_vec;
    logic [FSEL_W-1:0]            fsel_q;
    logic [PSEL_W-1:0]            psel_q;
    ftw_t                         inc_q;
    phase_t                       pofs_q;

    for (genvar g = 0; g < N_FREQ; g++) begin : g_freq
        ftw_t word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                word_q <= wr_data;
        end
        assign freq_vec[g] = word_q;
    end

    for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
        phase_t word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(PH_BASE + g))
                word_q <= wr_data[PH_W-1:0];
        end
        assign phase_vec[g] = word_q;
    end

    // Stage 0: capture the modulation pins alongside the register writes.
    always_ff @(posedge clk) begin
        if (rst) begin
            fsel_q <= '0;
            psel_q <= '0;
        end else begin
            fsel_q <= fsel;
            psel_q <= psel;
        end
    end

    // Stage 1: fetch the selected words.
    always_ff @(posedge clk) begin
        if (rst) begin
            inc_q  <= '0;
            pofs_q <= '0;
        end else begin
            inc_q  <= freq_vec[fsel_q];
            pofs_q <= phase_vec[psel_q];
        end
    end

    assign inc_o  = inc_q;
    assign pofs_o = pofs_q;

    // R7
    unused_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= ADDR_W'(PH_BASE + N_PHASE))
        |=> ($stable(freq_vec) && $stable(phase_vec)));

    // R8
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |=> (freq_vec[0] == $past(wr_data)));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ftw_t   inc_i,
    input  phase_t pofs_i,
    output phase_t idx_o
);
    ftw_t   acc_q;
    phase_t pw_q;
    phase_t idx_q;

    // Stage 2: accumulate, with the phase word delayed to stay aligned.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            pw_q  <= '0;
        end else begin
            acc_q <= acc_q + inc_i;
            pw_q  <= pofs_i;
        end
    end

    // Stage 3: truncate and add the phase offset, modulo the table size.
    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else
            idx_q <= acc_q[FTW_W-1 -: PH_W] + pw_q;
    end

    assign idx_o = idx_q;

    // R2
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_i == '0) |=> $stable(acc_q));
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
    import dds_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  phase_t  idx_i,
    output sample_t smp_o
);
    logic [AMP_W-1:0] qtab [0:QTR_N];

    for (genvar g = 0; g <= QTR_N; g++) begin : g_tab
        localparam int AV = quarter_amp(g);
        assign qtab[g] = AMP_W'(AV);
    end

    logic [1:0]       quad;
    logic [QTR_W:0]   fwd;
    logic [QTR_W:0]   rev;
    logic [AMP_W-1:0] amp;
    sample_t          val;
    sample_t          smp_q;

    always_comb begin
        quad = idx_i[PH_W-1 -: 2];
        fwd  = {1'b0, idx_i[QTR_W-1:0]};
        rev  = (QTR_W+1)'(QTR_N) - fwd;
        amp  = quad[0] ? qtab[rev] : qtab[fwd];
        val  = quad[1] ? (sample_t'(MID) - sample_t'(amp))
                       : (sample_t'(MID) + sample_t'(amp));
    end

    // Stage 4: registered lookup.
    always_ff @(posedge clk) begin
        if (rst)
            smp_q <= sample_t'(MID);
        else
            smp_q <= val;
    end

    assign smp_o = smp_q;

    // R5
    rom_range_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_q >= sample_t'(1)) && (smp_q <= sample_t'(2 * MID - 1)));
endmodule

// File: rtl/dds_modulator.sv
module dds_modulator
    import dds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FTW_W-1:0]  wr_data,
    input  logic [FSEL_W-1:0] tone_sel,
    input  logic [PSEL_W-1:0] shift_sel,
    output logic [OUT_W-1:0]  sample
);
    ftw_t    inc_w;
    phase_t  pofs_w;
    phase_t  idx_w;
    sample_t rom_w;

    dds_regbank u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .fsel    (tone_sel),
        .psel    (shift_sel),
        .inc_o   (inc_w),
        .pofs_o  (pofs_w)
    );

    dds_phase_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (inc_w),
        .pofs_i (pofs_w),
        .idx_o  (idx_w)
    );

    dds_sine_rom u_rom (
        .clk   (clk),
        .rst   (rst),
        .idx_i (idx_w),
        .smp_o (rom_w)
    );

    // Stages 5..: output delay that pads the pipeline to PIPE_LAT.
    logic [OUT_DLY:0][OUT_W-1:0] chain;
    assign chain[0] = rom_w;

    for (genvar i = 0; i < OUT_DLY; i++) begin : g_dly
        sample_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= sample_t'(MID);
            else
                q <= chain[i];
        end
        assign chain[i+1] = q;
    end

    assign sample = chain[OUT_DLY];

    // R1
    reset_mid_chk: assert property (@(posedge clk)
        $past(rst) |-> (sample == sample_t'(MID)));
endmodule

// File: tb/dds_modulator_bench.sv
module dds_modulator_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tone_sel = 1'b0;
    logic [1:0]  shift_sel = '0;
    logic [9:0]  sample;

    int    n_checks = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    logic [15:0] lf = 16'hACE1;

    always #10 clk = ~clk;

    dds_modulator u_dds_modulator (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tone_sel  (tone_sel),
        .shift_sel (shift_sel),
        .sample    (sample)
    );

    function automatic int sine_ref(int k);
        real v;
        int  r;
        v = 511.0 * $sin(2.0 * 3.14159265358979323846 * real'(k) / 4096.0);
        r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
        return 512 + r;
    endfunction

    task automatic check(string req, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s: sample=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Reference built from R2..R7: sample(n) = table(top12(A(n-4)) + P(n-6)),
    // A(n) = A(n-1) + F(n-2), where X(k) uses words and pins at edge k.
    logic [31:0] mf [2];
    logic [11:0] mp [4];
    logic [31:0] fh [3];
    logic [11:0] ph [7];
    logic [31:0] ah [5];
    logic [31:0] macc;
    int          exp_q = 512;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) mf[i] = '0;
            for (int i = 0; i < 4; i++) mp[i] = '0;
            for (int i = 0; i < 3; i++) fh[i] = '0;
            for (int i = 0; i < 7; i++) ph[i] = '0;
            for (int i = 0; i < 5; i++) ah[i] = '0;
            macc  = '0;
            exp_q = 512;
        end else begin
            if (wr_en) begin
                if (wr_addr < 3'd2)
                    mf[wr_addr[0]] = wr_data;
                else if (wr_addr < 3'd6)
                    mp[wr_addr - 3'd2] = wr_data[11:0];
            end
            for (int i = 2; i > 0; i--) fh[i] = fh[i-1];
            fh[0] = mf[tone_sel];
            for (int i = 6; i > 0; i--) ph[i] = ph[i-1];
            ph[0] = mp[shift_sel];
            macc = macc + fh[2];
            for (int i = 4; i > 0; i--) ah[i] = ah[i-1];
            ah[0] = macc;
            exp_q = sine_ref(int'(ah[4][31:20] + ph[6]));
        end
        cmp_on = 1'b1;
    end

    always @(negedge clk) begin
        if (cmp_on)
            check(cur_req, int'(sample), exp_q);
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lf_step();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tone_sel = 1'b0; shift_sel = '0;
        idle(3);
        rst = 1'b0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(4);
        check("R1", int'(sample), 512);
        rst = 1'b0;
        idle(6);
        check("R1", int'(sample), 512);

        // R5: exhaustive walk of the table
        cur_req = "R5";
        wr(3'd0, 32'h0010_0000);
        idle(4200);

        // R2: wrap with large tuning words
        cur_req = "R2";
        wr(3'd0, 32'hF000_0001);
        idle(150);
        wr(3'd0, 32'hFFFF_FFFF);
        idle(150);
        wr(3'd0, 32'h0);
        idle(20);

        // R3: two-tone switching under a pseudo-random bit stream
        cur_req = "R3";
        wr(3'd0, 32'h0030_0000);
        wr(3'd1, 32'h0770_0000);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            lf_step();
            tone_sel = lf[0];
        end
        tone_sel = 1'b0;

        // R4: four phase offsets, including wrap past 4095
        cur_req = "R4";
        wr(3'd2, 32'd0);
        wr(3'd3, 32'd1024);
        wr(3'd4, 32'd2048);
        wr(3'd5, 32'd4095);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lf_step();
            shift_sel = (i < 200) ? 2'(i % 4) : lf[1:0];
        end
        shift_sel = '0;

        // R7: unused addresses, upper data bits, unselected targets
        cur_req = "R7";
        wr(3'd6, 32'hDEAD_BEEF);
        wr(3'd7, 32'h1234_5678);
        idle(20);
        wr(3'd2, 32'hABCD_E400);
        idle(20);
        wr(3'd1, 32'h0);
        wr(3'd5, 32'd7);
        idle(30);

        // R8: one write every clock
        cur_req = "R8";
        @(negedge clk);
        for (int i = 0; i < 200; i++) begin
            lf_step();
            wr_en = 1'b1;
            wr_addr = (i % 2 == 0) ? 3'd0 : 3'd2;
            wr_data = {lf, lf ^ 16'h5A5A};
            tone_sel = lf[3];
            @(negedge clk);
        end
        wr_en = 1'b0;
        tone_sel = 1'b0;
        idle(20);

        // R6: latency of a phase write with a frozen accumulator
        cur_req = "R6";
        do_reset();
        idle(8);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'd1024;
        @(negedge clk);
        wr_en = 1'b0;
        idle(5);
        check("R6", int'(sample), 512);
        idle(1);
        check("R6", int'(sample), 1023);
        wr(3'd2, 32'd0);
        idle(8);

        // R6: latency of a one-cycle tone select
        wr(3'd1, 32'h4000_0000);
        idle(8);
        check("R6", int'(sample), 512);
        @(negedge clk);
        tone_sel = 1'b1;
        @(negedge clk);
        tone_sel = 1'b0;
        idle(5);
        check("R6", int'(sample), 512);
        idle(1);
        check("R6", int'(sample), 1023);
        idle(4);

        // R6: latency of a phase select change
        wr(3'd5, 32'd2048);
        idle(8);
        @(negedge clk);
        shift_sel = 2'd3;
        @(negedge clk);
        idle(5);
        check("R6", int'(sample), 1023);
        idle(1);
        check("R6", int'(sample), 1);
        idle(10);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule